// File: doc/BRIEF.md
# Flash Query and Identifier Read Responder

This block supplies the read word that a parallel flash bank returns while it sits in query mode or in identifier mode. A bus read offers a byte offset, the read size and three width settings: the bank width on the bus, the width at which each device is wired, and the widest mode that device supports. The block turns the offset into the device's own query index, fetches one byte from a query table or one identifier code, widens it as a device of that kind would, and copies the result into every device slot of the bank.

Reads larger than the bank are split into several bank-wide fetches at consecutive bank-width offsets, and the pieces are placed side by side in the returned word. The query table is computed at elaboration from parameters describing the device size, the erase blocks and the write buffer. The command handling that enters these modes and the array storage lie outside the block. All widths are given as log2 of a byte count (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = unsupported). The mode input is 0 for query and 1 for identifier.

Top module: `cfi_query_responder`

## Requirements
- R1: After reset `rd_valid` is 0 and `rd_data` is 0. A read strobe in one cycle gives its result on `rd_data` with `rd_valid` high after the next rising edge; with no strobe `rd_valid` is low and `rd_data` keeps its last value.
- R2: The table or identifier index of a bank fetch is its byte offset shifted right by bank_log2 + max_log2 - dev_log2.
- R3: In query mode an index of 82 (0x52) or more yields zero, for any index value up to the offset width.
- R4: The query table returns 0x51, 0x52, 0x59 at indices 0x10, 0x11, 0x12, 0x01 at 0x13, the parameter DEV_SIZE_LOG2 at 0x27 and 0x01 (one uniform erase region) at 0x2C.
- R5: In query mode, when the device width differs from its maximum width, a 1-byte device repeats the table byte into every byte of its maximum width; any wider device then returns zero.
- R6: The per-device response, dev bytes wide, is copied into each device slot of the bank, slot s occupying bytes s*dev to s*dev+dev-1, up to the bank width.
- R7: In identifier mode the low 8 bits of the index choose the response: 0 gives the 16-bit MFR_CODE, 1 gives the 16-bit DEV_CODE, any other value gives zero.
- R8: A read wider than the bank is built from fetches at offset + k*bank bytes, fetch k occupying bytes k*bank upward of `rd_data`.
- R9: Bytes of `rd_data` at or above the read size are zero.
- R10: A width code of 3 in any width input, a device width larger than the bank width, or a device width larger than its maximum width returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe, one cycle per read |
| mode_ident | input | 1 | 0 = query table, 1 = identifier codes |
| bank_wlog | input | 2 | log2 of bank width in bytes |
| dev_wlog | input | 2 | log2 of the width each device is wired at |
| max_wlog | input | 2 | log2 of the device's widest mode |
| acc_wlog | input | 2 | log2 of the read size in bytes |
| offset | input | ADDR_W | Byte offset of the read |
| rd_valid | output | 1 | High for one cycle with each result |
| rd_data | output | 32 | Assembled read word |

## Verification
Every result is due exactly one rising edge after the cycle in which `rd_en` is high: the index, fetch, widening, replication and merge are combinational and only the output register sits between strobe and port. The bench drives the strobe and all operands on a falling edge, drops the strobe on the next falling edge, and samples `rd_data` and `rd_valid` right there, half a period after the capturing edge. One idle cycle later it samples again to confirm the word is held and the valid flag has dropped.

// File: rtl/cfiq_pkg.sv
`timescale 1ns/1ps
package cfiq_pkg;

    localparam int TBL_LEN = 82;   // query table entries
    localparam int LANES   = 4;    // widest read in bytes / narrowest bank

    typedef enum logic {
        QM_QUERY = 1'b0,
        QM_IDENT = 1'b1
    } qmode_e;

    typedef logic [1:0] wlog_t;

    typedef struct packed {
        wlog_t bank;
        wlog_t dev;
        wlog_t maxw;
        wlog_t acc;
    } geom_t;

    typedef logic [LANES-1:0][7:0] word_t;

    // Supported geometry: every width at most 4 bytes, device not
    // wider than the bank nor than its own widest mode.
    function automatic logic geom_ok(geom_t g);
        return (g.bank != 2'd3) && (g.dev != 2'd3) && (g.maxw != 2'd3) &&
               (g.acc != 2'd3) && (g.dev <= g.bank) && (g.dev <= g.maxw);
    endfunction

    function automatic int unsigned bytes_of(wlog_t w);
        return 32'd1 << w;
    endfunction

    // Query table byte, computed from device parameters.
    function automatic logic [7:0] qtab_byte(
        logic [7:0] idx,
        int         dev_size_log2,
        int         blocks,
        int         sector_bytes,
        int         wbuf_log2
    );
        logic [31:0] blk_m1;
        logic [31:0] sec;
        blk_m1 = 32'(blocks - 1);
        sec    = 32'(sector_bytes);
        case (idx)
            8'h10: return 8'h51;
            8'h11: return 8'h52;
            8'h12: return 8'h59;
            8'h13: return 8'h01;
            8'h15: return 8'h31;
            8'h1B: return 8'h45;
            8'h1C: return 8'h55;
            8'h1F: return 8'h07;
            8'h20: return 8'h07;
            8'h21: return 8'h0A;
            8'h23: return 8'h04;
            8'h24: return 8'h04;
            8'h25: return 8'h04;
            8'h27: return 8'(dev_size_log2);
            8'h28: return 8'h02;
            8'h2A: return 8'(wbuf_log2);
            8'h2C: return 8'h01;
            8'h2D: return blk_m1[7:0];
            8'h2E: return blk_m1[15:8];
            8'h2F: return sec[15:8];
            8'h30: return sec[23:16];
            8'h31: return 8'h50;
            8'h32: return 8'h52;
            8'h33: return 8'h49;
            8'h34: return 8'h31;
            8'h35: return 8'h30;
            8'h3F: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cfiq_index.sv
`timescale 1ns/1ps
module cfiq_index
    import cfiq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  geom_t              geom,
    input  logic [ADDR_W-1:0]  offset,
    output logic [ADDR_W-1:0]  index
);

    logic [2:0] shamt;

    always_comb begin
        // bank + max - dev; illegal geometries are zeroed downstream
        shamt = 3'({1'b0, geom.bank} + {1'b0, geom.maxw} - {1'b0, geom.dev});
        index = offset >> shamt;
    end

endmodule

// File: rtl/cfiq_lane.sv
`timescale 1ns/1ps
module cfiq_lane
    import cfiq_pkg::*;
#(
    parameter int          ADDR_W        = 12,
    parameter int          DEV_SIZE_LOG2 = 23,
    parameter int          BLOCKS_PER_DEV = 128,
    parameter int          SECTOR_BYTES  = 65536,
    parameter int          WBUF_LOG2     = 11,
    parameter logic [15:0] MFR_CODE      = 16'h0089,
    parameter logic [15:0] DEV_CODE      = 16'h0018
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_ident,
    input  geom_t              geom,
    input  logic [ADDR_W-1:0]  index,
    output word_t              lane_q
);

    logic [7:0]  tbl_b;
    word_t       base;
    word_t       pre;
    int unsigned bank_b;
    int unsigned dev_b;
    int unsigned max_b;

    always_comb begin
        bank_b = bytes_of(geom.bank);
        dev_b  = bytes_of(geom.dev);
        max_b  = bytes_of(geom.maxw);

        // fetch
        if (index < ADDR_W'(TBL_LEN))
            tbl_b = qtab_byte(index[7:0], DEV_SIZE_LOG2, BLOCKS_PER_DEV,
                              SECTOR_BYTES, WBUF_LOG2);
        else
            tbl_b = 8'h00;

        if (qmode_e'(mode_ident) == QM_IDENT) begin
            case (index[7:0])
                8'd0:    base = {16'h0000, MFR_CODE};
                8'd1:    base = {16'h0000, DEV_CODE};
                default: base = '0;
            endcase
        end else begin
            base = {24'h0, tbl_b};
        end

        // widen: narrow-mode part repeats its query byte
        pre = base;
        if (qmode_e'(mode_ident) == QM_QUERY && geom.dev != geom.maxw) begin
            if (geom.dev == 2'd0) begin
                for (int i = 0; i < LANES; i++)
                    pre[i] = (32'(i) < max_b) ? base[0] : 8'h00;
            end else begin
                pre = '0;
            end
        end

        // replicate per device slot across the bank
        for (int b = 0; b < LANES; b++)
            lane_q[b] = (32'(b) < bank_b) ? pre[2'(32'(b) & (dev_b - 1))] : 8'h00;

        if (!geom_ok(geom))
            lane_q = '0;
    end

    p_range_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (!mode_ident && index >= ADDR_W'(TBL_LEN)) |-> lane_q == '0);

    p_ident_other_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_ident && index[7:1] != 7'd0) |-> lane_q == '0);

    p_x8_repeat_r5: assert property (@(posedge clk) disable iff (rst)
        (!mode_ident && geom_ok(geom) && geom.dev == 2'd0 && geom.maxw != 2'd0
         && geom.bank != 2'd0) |-> lane_q[1] == lane_q[0]);

endmodule

// File: rtl/cfi_query_responder.sv
`timescale 1ns/1ps
module cfi_query_responder
    import cfiq_pkg::*;
#(
    parameter int          ADDR_W         = 12,
    parameter int          DEV_SIZE_LOG2  = 23,
    parameter int          BLOCKS_PER_DEV = 128,
    parameter int          SECTOR_BYTES   = 65536,
    parameter int          WBUF_LOG2      = 11,
    parameter logic [15:0] MFR_CODE       = 16'h0089,
    parameter logic [15:0] DEV_CODE       = 16'h0018
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              mode_ident,
    input  logic [1:0]        bank_wlog,
    input  logic [1:0]        dev_wlog,
    input  logic [1:0]        max_wlog,
    input  logic [1:0]        acc_wlog,
    input  logic [ADDR_W-1:0] offset,
    output logic              rd_valid,
    output logic [31:0]       rd_data
);

    geom_t      geom;
    word_t      lane_w [LANES];
    word_t      merged;
    int unsigned acc_b;
    int unsigned bank_m;

    assign geom = '{bank: bank_wlog, dev: dev_wlog, maxw: max_wlog, acc: acc_wlog};

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [ADDR_W-1:0] lane_off;
        logic [ADDR_W-1:0] lane_idx;

        assign lane_off = offset + (ADDR_W'(k) << bank_wlog);

        cfiq_index #(.ADDR_W(ADDR_W)) u_idx (
            .geom   (geom),
            .offset (lane_off),
            .index  (lane_idx)
        );

        cfiq_lane #(
            .ADDR_W         (ADDR_W),
            .DEV_SIZE_LOG2  (DEV_SIZE_LOG2),
            .BLOCKS_PER_DEV (BLOCKS_PER_DEV),
            .SECTOR_BYTES   (SECTOR_BYTES),
            .WBUF_LOG2      (WBUF_LOG2),
            .MFR_CODE       (MFR_CODE),
            .DEV_CODE       (DEV_CODE)
        ) u_lane (
            .clk        (clk),
            .rst        (rst),
            .mode_ident (mode_ident),
            .geom       (geom),
            .index      (lane_idx),
            .lane_q     (lane_w[k])
        );
    end

    // byte j of the word comes from fetch j/bank, byte j%bank
    always_comb begin
        acc_b  = bytes_of(acc_wlog);
        bank_m = bytes_of(bank_wlog) - 1;
        for (int j = 0; j < LANES; j++) begin
            if (32'(j) < acc_b)
                merged[j] = lane_w[2'(32'(j) >> bank_wlog)][2'(32'(j) & bank_m)];
            else
                merged[j] = 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en)
                rd_data <= merged;
        end
    end

    p_valid_tracks_r1: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    p_valid_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    p_size_mask_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && acc_wlog == 2'd0) |=> rd_data[31:8] == 24'h0);

    p_bad_geom_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (bank_wlog == 2'd3 || dev_wlog > bank_wlog)) |=> rd_data == 32'h0);

endmodule

// File: tb/cfi_query_responder_tb_top.sv
`timescale 1ns/1ps
module cfi_query_responder_tb_top;

    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rd_en = 1'b0;
    logic              mode_ident = 1'b0;
    logic [1:0]        bank_wlog = '0;
    logic [1:0]        dev_wlog = '0;
    logic [1:0]        max_wlog = '0;
    logic [1:0]        acc_wlog = '0;
    logic [ADDR_W-1:0] offset = '0;
    logic              rd_valid;
    logic [31:0]       rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    cfi_query_responder #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst(rst), .rd_en(rd_en), .mode_ident(mode_ident),
        .bank_wlog(bank_wlog), .dev_wlog(dev_wlog), .max_wlog(max_wlog),
        .acc_wlog(acc_wlog), .offset(offset),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    typedef struct packed {
        logic        m;
        logic [1:0]  b;
        logic [1:0]  d;
        logic [1:0]  x;
        logic [1:0]  a;
        logic [11:0] off;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 12'h010, 32'h00000051, 4'd4},  // R4
        '{1'b0, 2'd1, 2'd1, 2'd1, 2'd1, 12'h020, 32'h00000051, 4'd2},  // R2
        '{1'b0, 2'd2, 2'd1, 2'd1, 2'd2, 12'h044, 32'h00520052, 4'd6},  // R6
        '{1'b0, 2'd2, 2'd0, 2'd1, 2'd2, 12'h088, 32'h52525252, 4'd5},  // R5
        '{1'b0, 2'd2, 2'd0, 2'd0, 2'd2, 12'h048, 32'h59595959, 4'd6},  // R6
        '{1'b0, 2'd0, 2'd0, 2'd0, 2'd2, 12'h010, 32'h01595251, 4'd8},  // R8
        '{1'b0, 2'd1, 2'd1, 2'd1, 2'd2, 12'h020, 32'h00520051, 4'd8},  // R8
        '{1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 12'h110, 32'h00000000, 4'd3},  // R3
        '{1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 12'h02C, 32'h00000001, 4'd4},  // R4
        '{1'b0, 2'd1, 2'd1, 2'd1, 2'd1, 12'h04E, 32'h00000017, 4'd4},  // R4
        '{1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 12'h000, 32'h00000089, 4'd7},  // R7
        '{1'b1, 2'd1, 2'd1, 2'd1, 2'd1, 12'h002, 32'h00000018, 4'd7},  // R7
        '{1'b1, 2'd2, 2'd1, 2'd1, 2'd2, 12'h000, 32'h00890089, 4'd6},  // R6
        '{1'b1, 2'd2, 2'd0, 2'd0, 2'd2, 12'h004, 32'h18181818, 4'd6},  // R6
        '{1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 12'h002, 32'h00000000, 4'd7},  // R7
        '{1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 12'h100, 32'h00000089, 4'd7},  // R7
        '{1'b0, 2'd2, 2'd1, 2'd2, 2'd2, 12'h040, 32'h00000000, 4'd5},  // R5
        '{1'b0, 2'd3, 2'd0, 2'd0, 2'd2, 12'h010, 32'h00000000, 4'd10}, // R10
        '{1'b0, 2'd1, 2'd0, 2'd0, 2'd0, 12'h020, 32'h00000051, 4'd9},  // R9
        '{1'b0, 2'd0, 2'd1, 2'd1, 2'd0, 12'h010, 32'h00000000, 4'd10}  // R10
    };

    // ---------------- behavioural model from the requirements ----------------
    function automatic logic [7:0] m_tab(int i);
        case (i)
            16: return 8'h51;  17: return 8'h52;  18: return 8'h59;
            19: return 8'h01;  21: return 8'h31;  27: return 8'h45;
            28: return 8'h55;  31: return 8'h07;  32: return 8'h07;
            33: return 8'h0A;  35: return 8'h04;  36: return 8'h04;
            37: return 8'h04;  39: return 8'h17;  40: return 8'h02;
            42: return 8'h0B;  44: return 8'h01;  45: return 8'h7F;
            46: return 8'h00;  47: return 8'h00;  48: return 8'h01;
            49: return 8'h50;  50: return 8'h52;  51: return 8'h49;
            52: return 8'h31;  53: return 8'h30;  63: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [63:0] m_put(logic [63:0] v, int pos, int nb, logic [63:0] src);
        logic [63:0] msk = (64'd1 << (8 * nb)) - 64'd1;
        return (v & ~(msk << (8 * pos))) | ((src & msk) << (8 * pos));
    endfunction

    function automatic logic [63:0] m_fetch(bit m, int bw, int dw, int mw, int sh, int off);
        int          ix = off >> sh;
        logic [63:0] r;
        if (!m) begin
            if (ix >= 82) return 64'd0;
            r = 64'(m_tab(ix));
            if (dw != mw) begin
                if (dw != 1) return 64'd0;
                for (int i = 1; i < mw; i++) r = m_put(r, i, 1, 64'(m_tab(ix)));
            end
        end else begin
            if ((ix & 255) == 0)      r = 64'h0089;
            else if ((ix & 255) == 1) r = 64'h0018;
            else return 64'd0;
        end
        for (int i = dw; i < bw; i += dw) r = m_put(r, i, dw, r);
        return r & ((64'd1 << (8 * bw)) - 64'd1);
    endfunction

    function automatic logic [31:0] m_read(bit m, int b, int d, int x, int a, int off);
        int bw, dw, mw, aw;
        logic [63:0] r = 64'd0;
        if (b > 2 || d > 2 || x > 2 || a > 2 || d > b || d > x) return 32'd0;
        bw = 1 << b; dw = 1 << d; mw = 1 << x; aw = 1 << a;
        for (int i = 0; i < aw; i += bw)
            r = m_put(r, i, bw, m_fetch(m, bw, dw, mw, b + x - d, off + i));
        return 32'(r & ((64'd1 << (8 * aw)) - 64'd1));
    endfunction

    // ---------------- helpers ----------------
    task automatic do_read(bit m, int b, int d, int x, int a, int off,
                           output logic [31:0] got, output logic vld);
        @(negedge clk);
        mode_ident = m; bank_wlog = 2'(b); dev_wlog = 2'(d);
        max_wlog = 2'(x); acc_wlog = 2'(a); offset = ADDR_W'(off);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        got = rd_data;
        vld = rd_valid;
    endtask

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] got;
        logic        vld;
        logic [31:0] held;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset valid", 32'(rd_valid), 32'd0);
        check("R1 reset data", rd_data, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // vector table
        for (int v = 0; v < NV; v++) begin
            do_read(VECS[v].m, int'(VECS[v].b), int'(VECS[v].d), int'(VECS[v].x),
                    int'(VECS[v].a), int'(VECS[v].off), got, vld);
            check($sformatf("R%0d vector %0d", VECS[v].req, v), got, VECS[v].exp);
            check($sformatf("R1 valid vector %0d", v), 32'(vld), 32'd1);
        end

        // R1: hold after read, valid drops
        do_read(1'b0, 0, 0, 0, 0, 16, got, vld);
        held = got;
        @(negedge clk);
        check("R1 hold data", rd_data, held);
        check("R1 idle valid", 32'(rd_valid), 32'd0);
        offset = 12'h011;
        @(negedge clk);
        check("R1 no strobe keeps data", rd_data, held);

        // R2 R5 R6 R8 R9 R10 sweep against the model
        for (int m = 0; m < 2; m++)
            for (int b = 0; b < 4; b++)
                for (int d = 0; d < 3; d++)
                    for (int x = 0; x < 3; x++)
                        for (int a = 0; a < 3; a++)
                            for (int o = 0; o < 5; o++) begin
                                int offs [5] = '{32, 68, 136, 2, 88};
                                do_read(m[0], b, d, x, a, offs[o], got, vld);
                                check($sformatf("R2 R6 R8 sweep m%0d b%0d d%0d x%0d a%0d off%0h",
                                                m, b, d, x, a, offs[o]),
                                      got, m_read(m[0], b, d, x, a, offs[o]));
                            end

        // R1: reset clears a nonzero result
        do_read(1'b0, 0, 0, 0, 0, 16, got, vld);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears data", rd_data, 32'd0);
        rst = 1'b0;

        finish_run();
    end

endmodule